// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Sequencer

This block sits between a synchronous request port and an asynchronous DRAM. The DRAM has active-low row strobe, column strobe, write enable and output enable, one address bus that carries the row first and then the column, and one data bus used in both directions. A client hands over a read or a write with a full address through a valid/ready handshake. The sequencer latches the request, splits the address into row and column halves and drives the strobes in order. Read data comes back with a one-cycle valid pulse.

A per-request mode bit picks the strobe ordering. In early mode, output enable (reads) or write enable (writes) falls before the column strobe. In late mode it falls only after the column strobe. The device's access and cycle minimums are given in nanoseconds and converted to clock counts from the clock period parameter. A free-running timer requests a row-only refresh cycle at a fixed interval. The refreshed row steps through every row and wraps. A pending refresh is served before any waiting request once the current access is over.

Top module: `dram_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, all four strobes are high, `dram_dq_oe` is 0, `rd_valid` is 0 and `req_ready` is 1.
- R2: The request address is split as row = `req_addr[17:9]` and column = `req_addr[8:0]`. The row is on `dram_addr` in the cycle before and the cycle after the row strobe falls. The column is on `dram_addr` in the cycle before and the cycle after the column strobe falls.
- R3: For a read, `req_late`=0 (early) means `dram_oe_n` is already low when `dram_cas_n` falls. `req_late`=1 (late) means `dram_oe_n` is high when `dram_cas_n` falls and goes low afterwards, before the data is sampled. `dram_we_n` stays high throughout.
- R4: For a write, the same `req_late` encoding applies to `dram_we_n`: low before the column strobe falls when early, high at that edge and low afterwards when late. `dram_oe_n` stays high.
- R5: Each read returns exactly one `rd_valid` pulse, one cycle wide, in request order. It carries the byte sampled from `dram_dq_i` at a point where the row strobe has been low for at least ceil(T_RAC_NS/CLK_NS) cycles and the column strobe for at least ceil(T_CAC_NS/CLK_NS) cycles.
- R6: `dram_dq_oe` is 1 only during write accesses, and it is 1 whenever write enable is low with the column strobe low. It is never 1 while `dram_oe_n` is low.
- R7: Two successive falls of the row strobe are at least ceil(T_RC_NS/CLK_NS) cycles apart.
- R8: Two successive falls of the column strobe are at least ceil(T_PC_NS/CLK_NS) cycles apart.
- R9: Every REF_INTERVAL cycles, a refresh cycle runs: the row strobe goes low with the column strobe held high. The refreshed rows run 0, 1, 2, ... up to 2^ROW_W-1 and then wrap to 0. With no traffic, refreshes are exactly REF_INTERVAL cycles apart.
- R10: A pending refresh wins over a waiting request, so no refresh is delayed by more than two row cycles under continuous traffic.
- R11: The column strobe is low only while the row strobe is low, and output enable and write enable are never low together.
- R12: `req_ready` is 0 whenever the row strobe is low, so only one access is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_late | input | 1 | 1 = late strobe ordering, 0 = early |
| req_addr | input | ROW_W+COL_W | Full address, row in the upper half |
| req_wdata | input | DATA_W | Write byte |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | DATA_W | Read byte |
| dram_addr | output | ROW_W | Shared row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_o | output | DATA_W | Data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for the data pads; 0 = high impedance |
| dram_dq_i | input | DATA_W | Data from the DRAM |

## Verification
The hardest case to reach is a refresh timer that expires while a request is already waiting with valid held high. Only there does the priority decision between the two matter. To get there, the stimulus runs a long burst of accesses with valid asserted before ready rises, across several refresh intervals. A DRAM model checks that each refresh still arrives within two row cycles of its due time and that every read returns the byte last written. The model drives junk on the data pins until the access and column times have elapsed, so a sample taken too early returns wrong data. It also records the refreshed row so that the wrap after the last row can be observed.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_RAS,
    ST_COL,
    ST_CAS,
    ST_END
  } seq_state_t;

  // Round a nanosecond figure up to whole clock cycles.
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int sat0(input int a);
    return (a > 0) ? a : 0;
  endfunction

endpackage

// File: rtl/dram_gap_timer.sv
module dram_gap_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ok
);
  localparam int W = $clog2(LIMIT + 2);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)
      cnt_d = '0;
    else if (cnt_q < W'(LIMIT))
      cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= W'(LIMIT);
    else        cnt_q <= cnt_d;
  end

  assign ok = (cnt_q >= W'(LIMIT));

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int INTERVAL = 1560,
  parameter int ROW_W    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack,
  input  logic             done,
  output logic             pend,
  output logic [ROW_W-1:0] row
);
  localparam int IW = $clog2(INTERVAL);

  logic [IW-1:0]    tick_q, tick_d;
  logic             pend_q, pend_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             wrap;

  assign wrap = (tick_q == IW'(INTERVAL - 1));

  always_comb begin
    tick_d = wrap ? '0 : tick_q + IW'(1);
    pend_d = pend_q;
    if (ack)  pend_d = 1'b0;
    if (wrap) pend_d = 1'b1;
    row_d  = row_q;
    if (done) row_d = row_q + ROW_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      pend_q <= 1'b0;
      row_q  <= '0;
    end else begin
      tick_q <= tick_d;
      pend_q <= pend_d;
      row_q  <= row_d;
    end
  end

  assign pend = pend_q;
  assign row  = row_q;

endmodule

// File: rtl/dram_addr_path.sv
module dram_addr_path #(
  parameter int ROW_W  = 9,
  parameter int COL_W  = 9,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [ROW_W+COL_W-1:0] addr_in,
  input  logic [DATA_W-1:0]      wdata_in,
  input  logic                   sel_col,
  input  logic                   sel_ref,
  input  logic [ROW_W-1:0]       ref_row,
  output logic [ROW_W-1:0]       addr_out,
  output logic [DATA_W-1:0]      dq_out
);
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] wd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
      wd_q  <= '0;
    end else if (load) begin
      row_q <= addr_in[ROW_W+COL_W-1:COL_W];
      col_q <= addr_in[COL_W-1:0];
      wd_q  <= wdata_in;
    end
  end

  always_comb begin
    if (sel_ref)      addr_out = ref_row;
    else if (sel_col) addr_out = ROW_W'(col_q);
    else              addr_out = row_q;
  end

  assign dq_out = wd_q;

endmodule

// File: rtl/dram_access_fsm.sv
module dram_access_fsm
  import dram_seq_pkg::*;
#(
  parameter int CW      = 3,
  parameter int T_ASR   = 1,
  parameter int T_RAH   = 1,
  parameter int T_ASC   = 1,
  parameter int CAS_CYC = 4,
  parameter int REF_RAS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  input  logic req_late,
  input  logic ref_pend,
  input  logic rc_ok,
  input  logic pc_ok,
  output logic req_ready,
  output logic accept,
  output logic ref_ack,
  output logic ref_done,
  output logic ras_start,
  output logic cas_start,
  output logic sel_col,
  output logic sel_ref,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic oe_n,
  output logic dq_oe,
  output logic cap
);
  seq_state_t    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ref_q, ref_d;
  logic          wr_q, wr_d;
  logic          late_q, late_d;
  logic          last;
  logic          start_ref;
  logic          strobe_early, strobe_late, strobe_on;

  assign last      = (cnt_q == '0);
  assign req_ready = (state_q == ST_IDLE) && !ref_pend && rc_ok && pc_ok;
  assign accept    = req_ready && req_valid;
  assign start_ref = (state_q == ST_IDLE) && ref_pend && rc_ok;
  assign ref_ack   = start_ref;

  // Next state and phase counter
  always_comb begin
    state_d = state_q;
    cnt_d   = last ? cnt_q : cnt_q - CW'(1);
    ref_d   = ref_q;
    wr_d    = wr_q;
    late_d  = late_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_ref) begin
          state_d = ST_ROW;
          cnt_d   = CW'(T_ASR - 1);
          ref_d   = 1'b1;
          wr_d    = 1'b0;
          late_d  = 1'b0;
        end else if (accept) begin
          state_d = ST_ROW;
          cnt_d   = CW'(T_ASR - 1);
          ref_d   = 1'b0;
          wr_d    = req_write;
          late_d  = req_late;
        end
      end
      ST_ROW: if (last) begin
        state_d = ST_RAS;
        cnt_d   = ref_q ? CW'(REF_RAS - 1) : CW'(T_RAH - 1);
      end
      ST_RAS: if (last) begin
        state_d = ref_q ? ST_END : ST_COL;
        cnt_d   = CW'(T_ASC - 1);
      end
      ST_COL: if (last) begin
        state_d = ST_CAS;
        cnt_d   = CW'(CAS_CYC - 1);
      end
      ST_CAS: if (last) state_d = ST_END;
      ST_END: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ref_q   <= 1'b0;
      wr_q    <= 1'b0;
      late_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ref_q   <= ref_d;
      wr_q    <= wr_d;
      late_q  <= late_d;
    end
  end

  // Strobe decode from registered state
  assign strobe_early = !late_q && ((state_q == ST_COL) || (state_q == ST_CAS));
  assign strobe_late  = late_q && (state_q == ST_CAS) && (cnt_q != CW'(CAS_CYC - 1));
  assign strobe_on    = !ref_q && (strobe_early || strobe_late);

  assign ras_n   = !((state_q == ST_RAS) || (state_q == ST_COL) || (state_q == ST_CAS));
  assign cas_n   = (state_q != ST_CAS);
  assign oe_n    = !(strobe_on && !wr_q);
  assign we_n    = !(strobe_on && wr_q);
  assign dq_oe   = wr_q && !ref_q && ((state_q == ST_COL) || (state_q == ST_CAS));
  assign sel_col = (state_q == ST_COL) || (state_q == ST_CAS);
  assign sel_ref = ref_q;
  assign cap     = (state_q == ST_CAS) && last && !wr_q;

  assign ras_start = (state_q == ST_ROW) && last;
  assign cas_start = (state_q == ST_COL) && last;
  assign ref_done  = (state_q == ST_END) && ref_q;

endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_seq_pkg::*;
#(
  parameter int ROW_W        = 9,
  parameter int COL_W        = 9,
  parameter int DATA_W       = 8,
  parameter int CLK_NS       = 10,
  parameter int T_RAC_NS     = 60,
  parameter int T_RC_NS      = 110,
  parameter int T_CAC_NS     = 15,
  parameter int T_PC_NS      = 35,
  parameter int T_ASR        = 1,
  parameter int T_RAH        = 1,
  parameter int T_ASC        = 1,
  parameter int REF_INTERVAL = 1560
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic                   req_late,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rd_valid,
  output logic [DATA_W-1:0]      rd_data,
  output logic [ROW_W-1:0]       dram_addr,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [DATA_W-1:0]      dram_dq_o,
  output logic                   dram_dq_oe,
  input  logic [DATA_W-1:0]      dram_dq_i
);
  localparam int RAC_CYC = ns_to_cyc(T_RAC_NS, CLK_NS);
  localparam int RC_CYC  = ns_to_cyc(T_RC_NS, CLK_NS);
  localparam int CAC_CYC = ns_to_cyc(T_CAC_NS, CLK_NS);
  localparam int PC_CYC  = ns_to_cyc(T_PC_NS, CLK_NS);
  localparam int CAS_CYC = imax(imax(CAC_CYC, RAC_CYC - T_RAH - T_ASC), 2);
  localparam int RC_WAIT = sat0(RC_CYC - 1 - T_ASR);
  localparam int PC_WAIT = sat0(PC_CYC - 1 - T_ASR - T_RAH - T_ASC);
  localparam int MAXD    = imax(imax(imax(T_ASR, T_RAH), imax(T_ASC, CAS_CYC)), RAC_CYC);
  localparam int CW      = $clog2(MAXD + 1);

  logic             accept, ref_ack, ref_done, ref_pend;
  logic             ras_start, cas_start, rc_ok, pc_ok;
  logic             sel_col, sel_ref, cap;
  logic [ROW_W-1:0] ref_row;
  logic             rd_valid_q;
  logic [DATA_W-1:0] rd_data_q;

  dram_access_fsm #(
    .CW(CW), .T_ASR(T_ASR), .T_RAH(T_RAH), .T_ASC(T_ASC),
    .CAS_CYC(CAS_CYC), .REF_RAS(RAC_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_late(req_late),
    .ref_pend(ref_pend), .rc_ok(rc_ok), .pc_ok(pc_ok),
    .req_ready(req_ready), .accept(accept), .ref_ack(ref_ack), .ref_done(ref_done),
    .ras_start(ras_start), .cas_start(cas_start),
    .sel_col(sel_col), .sel_ref(sel_ref),
    .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n), .oe_n(dram_oe_n),
    .dq_oe(dram_dq_oe), .cap(cap)
  );

  dram_gap_timer #(.LIMIT(RC_WAIT)) u_rc_timer (
    .clk(clk), .rst_n(rst_n), .start(ras_start), .ok(rc_ok)
  );

  dram_gap_timer #(.LIMIT(PC_WAIT)) u_pc_timer (
    .clk(clk), .rst_n(rst_n), .start(cas_start), .ok(pc_ok)
  );

  dram_refresh_sched #(.INTERVAL(REF_INTERVAL), .ROW_W(ROW_W)) u_refresh (
    .clk(clk), .rst_n(rst_n), .ack(ref_ack), .done(ref_done),
    .pend(ref_pend), .row(ref_row)
  );

  dram_addr_path #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .addr_in(req_addr), .wdata_in(req_wdata),
    .sel_col(sel_col), .sel_ref(sel_ref), .ref_row(ref_row),
    .addr_out(dram_addr), .dq_out(dram_dq_o)
  );

  // Read return register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= cap;
      if (cap) rd_data_q <= dram_dq_i;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

endmodule

// File: rtl/dram_seq_chk.sv
module dram_seq_chk #(
  parameter int AW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic          oe_n,
  input logic          dq_oe,
  input logic          rd_valid,
  input logic          req_ready,
  input logic [AW-1:0] addr,
  input int            rc_lim,
  input int            pc_lim
);
  logic ras_q, cas_q, ras_fell, cas_fell;
  int   ras_gap, cas_gap;

  assign ras_fell = ras_q && !ras_n;
  assign cas_fell = cas_q && !cas_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q   <= 1'b1;
      cas_q   <= 1'b1;
      ras_gap <= 1 << 20;
      cas_gap <= 1 << 20;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      if (ras_fell)             ras_gap <= 1;
      else if (ras_gap < 1<<20) ras_gap <= ras_gap + 1;
      if (cas_fell)             cas_gap <= 1;
      else if (cas_gap < 1<<20) cas_gap <= cas_gap + 1;
    end
  end

  // R11
  cas_in_ras_chk: assert property (@(posedge clk) disable iff (!rst_n) !cas_n |-> !ras_n);
  // R11
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !oe_n |-> we_n);
  // R6
  dq_dir_chk: assert property (@(posedge clk) disable iff (!rst_n) dq_oe |-> oe_n);
  // R5
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |=> !rd_valid);
  // R7
  ras_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) ras_fell |-> (ras_gap >= rc_lim));
  // R8
  cas_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) cas_fell |-> (cas_gap >= pc_lim));
  // R2
  row_stable_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(ras_n) |-> $stable(addr));
  // R2
  col_stable_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(cas_n) |-> $stable(addr));
  // R12
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n) !ras_n |-> !req_ready);

endmodule

bind dram_seq dram_seq_chk #(.AW(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n), .oe_n(dram_oe_n),
  .dq_oe(dram_dq_oe), .rd_valid(rd_valid), .req_ready(req_ready),
  .addr(dram_addr), .rc_lim(RC_CYC), .pc_lim(PC_CYC)
);

// File: tb/dram_seq_tb.sv
module dram_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int REF_INT    = 120;
  localparam int RC         = 11;  // ceil(110/10)
  localparam int PC         = 4;   // ceil(35/10)
  localparam int RAC        = 6;   // ceil(60/10)
  localparam int CAC        = 2;   // ceil(15/10)

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0, req_late = 1'b0;
  logic        req_ready;
  logic [17:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic [8:0]  dram_addr;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [7:0]  dram_dq_o, dram_dq_i;

  dram_seq #(.REF_INTERVAL(REF_INT)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_late(req_late), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_dq_o(dram_dq_o), .dram_dq_oe(dram_dq_oe), .dram_dq_i(dram_dq_i)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard state
  typedef struct packed {
    logic       wr;
    logic       late;
    logic [8:0] row;
    logic [8:0] col;
  } acc_t;

  acc_t       exp_acc[$];
  logic [7:0] exp_rd[$];
  logic [7:0] shadow[int];
  logic [7:0] mem[int];

  task automatic do_access(input bit wr, input bit late, input logic [17:0] a, input logic [7:0] d);
    acc_t e;
    e.wr = wr; e.late = late; e.row = a[17:9]; e.col = a[8:0];
    exp_acc.push_back(e);
    if (wr) shadow[int'(a)] = d;
    else    exp_rd.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00);
    req_write = wr; req_late = late; req_addr = a; req_wdata = d;
    req_valid = 1'b1;
    forever begin
      if (req_ready) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  // Read monitor (R5)
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_rd.size() == 0) check(1'b0, "R5 unexpected read pulse", rd_data, 0);
      else begin
        logic [7:0] e;
        e = exp_rd.pop_front();
        check(rd_data == e, "R5 read data", rd_data, e);
      end
    end
  end

  // DRAM model, sampled on the falling clock edge
  logic       p_ras = 1'b1, p_cas = 1'b1;
  logic [8:0] p_addr = '0, m_row = '0, m_col = '0;
  int         ras_cnt = 0, cas_cnt = 0, ras_gap = 1000, cas_gap = 1000;
  bit         had_cas = 0, wrote = 0, acc_since_ref = 0, prev_clean = 0;
  int         cyc = 0, ref_seen = 0, exp_ref_row = 0, last_ref_cyc = -1;
  logic [7:0] rd_byte = 8'h00;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++; ras_gap++; cas_gap++;
      if (p_ras && !dram_ras_n) begin
        check(ras_gap >= RC, "R7 row strobe spacing", ras_gap, RC);
        ras_gap = 0;
        check(dram_addr == p_addr, "R2 row setup/hold", dram_addr, p_addr);
        check(!req_ready, "R12 ready low during access", req_ready, 0);
        m_row = dram_addr; had_cas = 0; ras_cnt = 0;
      end
      if (!dram_ras_n) ras_cnt++;
      if (p_cas && !dram_cas_n) begin
        check(!dram_ras_n, "R11 column strobe inside row strobe", dram_ras_n, 0);
        check(cas_gap >= PC, "R8 column strobe spacing", cas_gap, PC);
        cas_gap = 0;
        check(dram_addr == p_addr, "R2 col setup/hold", dram_addr, p_addr);
        m_col = dram_addr; had_cas = 1; cas_cnt = 0; acc_since_ref = 1;
        if (exp_acc.size() == 0) check(1'b0, "R2 unexpected access", 0, 1);
        else begin
          acc_t e;
          e = exp_acc.pop_front();
          check(m_row == e.row, "R2 row address", m_row, e.row);
          check(m_col == e.col, "R2 column address", m_col, e.col);
          if (e.wr) begin
            check(dram_we_n == e.late, "R4 write enable ordering", dram_we_n, e.late);
            check(dram_oe_n, "R4 output enable high in write", dram_oe_n, 1);
          end else begin
            check(dram_oe_n == e.late, "R3 output enable ordering", dram_oe_n, e.late);
            check(dram_we_n, "R3 write enable high in read", dram_we_n, 1);
          end
        end
      end
      if (!dram_cas_n) cas_cnt++;
      if (!dram_cas_n && !dram_we_n && !wrote) begin
        check(dram_dq_oe, "R6 data driven during write", dram_dq_oe, 1);
        mem[int'({m_row, m_col})] = dram_dq_o;
        wrote = 1;
      end
      if (dram_cas_n) wrote = 0;
      if (dram_dq_oe && !dram_oe_n) check(1'b0, "R6 drive while output enabled", 1, 0);
      if (!p_ras && dram_ras_n && !had_cas) begin
        ref_seen++;
        check(m_row == exp_ref_row[8:0], "R9 refresh row", m_row, exp_ref_row);
        exp_ref_row = (exp_ref_row + 1) % 512;
        if (last_ref_cyc >= 0) begin
          if (!acc_since_ref && prev_clean)
            check(cyc - last_ref_cyc == REF_INT, "R9 idle refresh interval", cyc - last_ref_cyc, REF_INT);
          check(cyc - last_ref_cyc <= REF_INT + 2*RC, "R10 refresh delay", cyc - last_ref_cyc, REF_INT + 2*RC);
        end
        prev_clean = !acc_since_ref;
        last_ref_cyc = cyc; acc_since_ref = 0;
      end
      rd_byte = mem.exists(int'({m_row, m_col})) ? mem[int'({m_row, m_col})] : 8'h00;
      p_ras = dram_ras_n; p_cas = dram_cas_n; p_addr = dram_addr;
    end
  end

  // Junk until access and column times have elapsed (R5)
  assign dram_dq_i = (!dram_oe_n && !dram_cas_n && ras_cnt >= RAC && cas_cnt >= CAC) ? rd_byte : 8'hEE;

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [17:0] a;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes high in reset",
          {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hF);
    check(!dram_dq_oe && !rd_valid, "R1 bus released in reset", {dram_dq_oe, rd_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready, "R1 ready after reset", req_ready, 1);
    check(dram_ras_n && dram_cas_n, "R1 strobes high after reset", {dram_ras_n, dram_cas_n}, 3);

    // Corner addresses, all four orderings
    do_access(1, 0, 18'h00000, 8'h5A);
    do_access(1, 1, 18'h3FFFF, 8'hA5);
    do_access(1, 0, {9'h1FF, 9'h000}, 8'h3C);
    do_access(1, 1, {9'h000, 9'h1FF}, 8'hC3);
    do_access(0, 0, 18'h00000, 8'h00);
    do_access(0, 1, 18'h3FFFF, 8'h00);
    do_access(0, 1, {9'h1FF, 9'h000}, 8'h00);
    do_access(0, 0, {9'h000, 9'h1FF}, 8'h00);
    do_access(0, 0, 18'h15555, 8'h00);  // never written: reads 0

    // Mixed pattern
    for (int i = 0; i < 16; i++) begin
      a = 18'((i * 46039 + 5) & 18'h3FFFF);
      do_access(1, i[0], a, 8'(i * 29 + 7));
    end
    for (int i = 0; i < 16; i++) begin
      a = 18'((i * 46039 + 5) & 18'h3FFFF);
      do_access(0, i[1], a, 8'h00);
    end

    // Idle: refresh interval measured without traffic (R9)
    repeat (4 * REF_INT) @(negedge clk);

    // Continuous traffic across several refresh intervals (R10)
    for (int i = 0; i < 80; i++) begin
      a = 18'((i * 7919 + 33) & 18'h3FFFF);
      do_access(i[2], i[0], a, 8'(i ^ 8'h96));
    end

    // Run until the refresh row has wrapped (R9)
    while (ref_seen < 515) @(negedge clk);
    repeat (20) @(negedge clk);
    check(exp_rd.size() == 0, "R5 every read returned", exp_rd.size(), 0);
    check(exp_acc.size() == 0, "R2 every access seen", exp_acc.size(), 0);
    finish_run();
  end

endmodule